// File: doc/BRIEF.md
# Snoop Control Register Block

This block is the register front end of a multiprocessor snoop control unit. It sits on a simple strobe-based read/write bus: the requester presents a byte offset, a write flag and write data together with a one-cycle strobe. One cycle later the block returns the registered read data and, when the access was not legal, an error pulse. It holds a single snoop enable bit, which also drives an output toward the coherency logic. It reports the processor configuration through a read-only word, and it provides a CPU status word and an invalidate-all command register. Both of these read as zero, and a write to the command register is accepted and discarded.

The processor count is a build-time parameter from 1 to 4. Only the low byte of the offset is decoded, so the four-word window repeats every 256 bytes.

Top module: `scu_reg_block`

## Requirements
- R1: After reset, the enable bit is 0, `rdata_o` is 0 and `err_o` is 0.
- R2: A write strobe at offset 0x00 stores `wdata_i[0]` into the enable bit, which appears on `snoop_en_o` one cycle later. A read strobe at 0x00 returns the enable bit in bit 0 and zeros above it, one cycle later.
- R3: A read at offset 0x04 returns N ones at bits 4 and up, ORed with N-1 in bits 1:0, where N is `NUM_CPU`. With N=4 this is 0x000000F3.
- R4: A read at offset 0x08 returns 0.
- R5: A read at offset 0x0C returns 0. A write there raises no error and leaves the enable bit unchanged.
- R6: A read or write strobe at any low-byte offset other than 0x00, 0x04, 0x08 and 0x0C gives `err_o`=1 one cycle later, with `rdata_o`=0 in that cycle. This includes unaligned offsets such as 0x01.
- R7: A write at offset 0x04 or 0x08 gives `err_o`=1 one cycle later and leaves the enable bit unchanged.
- R8: Offset bits above bit 7 are ignored, so offset 0xA00 behaves exactly like 0x000.
- R9: In a cycle that follows no strobe, or follows a write strobe, `rdata_o` is 0 and `err_o` is 0 unless R6 or R7 applies. Every error pulse therefore lasts one cycle for each offending strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset; only bits 7:0 are decoded |
| wdata_i | input | DATA_W | Write data; only bit 0 is stored |
| rdata_o | output | DATA_W | Registered read data |
| err_o | output | 1 | One-cycle error pulse |
| snoop_en_o | output | 1 | Current enable bit |

## Verification
The enable update from a control write and the read-data register both change on the same clock edge. A control write followed in the very next cycle by a read of the control word therefore sets the returned value and the stored bit in the same cycle. The bench provokes this with back-to-back strobes. It judges the case by requiring a zero read result for the write cycle and, one cycle later, the newly written bit on both `rdata_o` and `snoop_en_o`. Random traffic mixes legal offsets carrying random upper bits with arbitrary low bytes, so that error pulses land directly next to legal reads.

// File: rtl/scu_regs_pkg.sv
package scu_regs_pkg;
  localparam int CNT_W    = 2;
  localparam int MASK_LSB = 4;

  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_CFG   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_INVAL = 8'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CFG,
    SEL_STAT,
    SEL_INVAL
  } scu_sel_e;
endpackage

// File: rtl/scu_addr_decode.sv
module scu_addr_decode
  import scu_regs_pkg::*;
(
  input  logic [7:0] off_i,
  input  logic       we_i,
  output scu_sel_e   sel_o,
  output logic       bad_o
);
  always_comb begin
    case (off_i)
      OFF_CTRL:  sel_o = SEL_CTRL;
      OFF_CFG:   sel_o = SEL_CFG;
      OFF_STAT:  sel_o = SEL_STAT;
      OFF_INVAL: sel_o = SEL_INVAL;
      default:   sel_o = SEL_NONE;
    endcase
  end

  // read-only words reject writes
  assign bad_o = (sel_o == SEL_NONE) ||
                 (we_i && ((sel_o == SEL_CFG) || (sel_o == SEL_STAT)));
endmodule

// File: rtl/scu_cfg_word.sv
module scu_cfg_word
  import scu_regs_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 32
) (
  output logic [DATA_W-1:0] cfg_o
);
  localparam int CNT_VAL = NUM_CPU - 1;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    if (g >= MASK_LSB && g < MASK_LSB + NUM_CPU) begin : g_mask
      assign cfg_o[g] = 1'b1;
    end else if (g < CNT_W) begin : g_cnt
      assign cfg_o[g] = ((CNT_VAL >> g) & 1) != 0;
    end else begin : g_zero
      assign cfg_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/scu_reg_block.sv
module scu_reg_block
  import scu_regs_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              snoop_en_o
);
  scu_sel_e          sel;
  logic              bad;
  logic [DATA_W-1:0] cfg_word;
  logic              ctrl_q;
  logic              err_q;
  logic [DATA_W-1:0] rdata_q;
  logic              unused_bits;

  assign unused_bits = ^{addr_i[ADDR_W-1:8], wdata_i[DATA_W-1:1]};

  scu_addr_decode u_dec (
    .off_i (addr_i[7:0]),
    .we_i  (we_i),
    .sel_o (sel),
    .bad_o (bad)
  );

  scu_cfg_word #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_cfg (
    .cfg_o (cfg_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      err_q   <= req_i && bad;
      rdata_q <= '0;
      if (req_i && !bad) begin
        if (we_i) begin
          if (sel == SEL_CTRL) ctrl_q <= wdata_i[0];
        end else begin
          case (sel)
            SEL_CTRL: rdata_q <= {{(DATA_W-1){1'b0}}, ctrl_q};
            SEL_CFG:  rdata_q <= cfg_word;
            default:  rdata_q <= '0;
          endcase
        end
      end
    end
  end

  assign rdata_o    = rdata_q;
  assign err_o      = err_q;
  assign snoop_en_o = ctrl_q;
endmodule

// File: rtl/scu_reg_block_chk.sv
module scu_reg_block_chk #(
  parameter int NUM_CPU = 4,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              snoop_en_o
);
  logic [DATA_W-1:0] cfg_ref;
  always_comb begin
    cfg_ref = DATA_W'(NUM_CPU - 1);
    for (int i = 0; i < NUM_CPU; i++) cfg_ref[4+i] = 1'b1;
  end

  logic ctrl_wr;
  assign ctrl_wr = req_i && we_i && (addr_i[7:0] == 8'h00);

  a_r2_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> snoop_en_o == $past(wdata_i[0]));

  a_r5_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(snoop_en_o));

  a_r3_cfg_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[7:0] == 8'h04) |=> (rdata_o == cfg_ref && !err_o));

  a_r4_status_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[7:0] == 8'h08) |=> (rdata_o == '0 && !err_o));

  a_r6_err_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);

  a_r7_ro_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i[7:0] == 8'h04 || addr_i[7:0] == 8'h08)) |=> err_o);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!err_o && rdata_o == '0));
endmodule

bind scu_reg_block scu_reg_block_chk #(
  .NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .err_o(err_o), .snoop_en_o(snoop_en_o)
);

// File: tb/tb_scu_reg_block.sv
module tb_scu_reg_block;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CPU    = 4;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              err;
  logic              snoop_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit exp_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scu_reg_block #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .snoop_en_o(snoop_en)
  );

  function automatic logic [DATA_W-1:0] cfg_expect();
    logic [DATA_W-1:0] v = '0;
    v[1:0] = 2'(NUM_CPU - 1);
    for (int i = 0; i < NUM_CPU; i++) v = v | (DATA_W'(1) << (4 + i));
    return v;
  endfunction

  // returns {err, rdata} per the requirements and updates exp_en
  function automatic logic [DATA_W:0] model(bit w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    logic [7:0] o = a[7:0];
    if (o != 8'h00 && o != 8'h04 && o != 8'h08 && o != 8'h0C) return {1'b1, {DATA_W{1'b0}}};
    if (w) begin
      if (o == 8'h04 || o == 8'h08) return {1'b1, {DATA_W{1'b0}}};
      if (o == 8'h00) exp_en = d[0];
      return '0;
    end
    if (o == 8'h00) return {1'b0, {(DATA_W-1){1'b0}}, exp_en};
    if (o == 8'h04) return {1'b0, cfg_expect()};
    return '0;
  endfunction

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, bit w, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    logic [DATA_W:0] e;
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    e = model(w, a, d);
    @(negedge clk);
    req = 0; we = 0;
    check({tag, " err"}, DATA_W'(err), DATA_W'(e[DATA_W]));
    check({tag, " rdata"}, rdata, e[DATA_W-1:0]);
    check({tag, " enable"}, DATA_W'(snoop_en), DATA_W'(exp_en));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5C0FFEE));
    #(CLK_PERIOD * 3);
    // R1 reset state
    check("R1 rdata", rdata, '0);
    check("R1 err", DATA_W'(err), '0);
    check("R1 enable", DATA_W'(snoop_en), '0);
    @(negedge clk); rst_n = 1;

    access("R2 set", 1, 12'h000, 32'hFFFF_FFFF);
    access("R2 read", 0, 12'h000, 0);
    access("R2 clear", 1, 12'h000, 32'hFFFF_FFFE);
    access("R2 read0", 0, 12'h000, 0);
    access("R3 cfg", 0, 12'h004, 0);
    check("R3 const", cfg_expect(), 32'h0000_00F3);
    access("R4 status", 0, 12'h008, 0);
    access("R2 set again", 1, 12'h000, 32'h1);
    access("R5 inval write", 1, 12'h00C, 32'h0);
    access("R5 inval read", 0, 12'h00C, 0);
    access("R6 unaligned", 0, 12'h001, 0);
    access("R6 hole", 1, 12'h010, 32'h0);
    access("R6 top", 0, 12'h0FC, 0);
    access("R7 cfg write", 1, 12'h004, 32'h0);
    access("R7 status write", 1, 12'h008, 32'h0);
    access("R8 alias clear", 1, 12'hA00, 32'h0);
    access("R8 alias cfg", 0, 12'hF04, 0);

    // back-to-back: control write then immediate read
    @(negedge clk); req = 1; we = 1; addr = 12'h000; wdata = 32'h1; void'(model(1, 12'h000, 32'h1));
    @(negedge clk); we = 0;
    check("R9 write cycle rdata", rdata, '0);
    check("R9 write cycle err", DATA_W'(err), '0);
    @(negedge clk); req = 0;
    check("R2 b2b rdata", rdata, 32'h1);
    check("R2 b2b enable", DATA_W'(snoop_en), 32'h1);
    // illegal then legal, back-to-back
    @(negedge clk); req = 1; we = 0; addr = 12'h055;
    @(negedge clk); addr = 12'h004;
    check("R6 b2b err", DATA_W'(err), 32'h1);
    check("R6 b2b rdata", rdata, '0);
    @(negedge clk); req = 0;
    check("R3 b2b err", DATA_W'(err), '0);
    check("R3 b2b rdata", rdata, cfg_expect());
    @(negedge clk);
    check("R9 idle err", DATA_W'(err), '0);
    check("R9 idle rdata", rdata, '0);

    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom);
      if ($urandom_range(3) != 0) a[7:0] = 8'($urandom_range(3) * 4);
      access("R8 random", $urandom_range(1) == 1, a, $urandom);
    end
    finish_run();
  end
endmodule